// File: doc/BRIEF.md
# Two-Register Self-Test Sequencer

This block is the controller for a self-test of two combinational networks wired in a ring through two multi-mode test registers, A and B. Network 1 takes register A as its input and feeds register B. Network 2 takes register B as its input and feeds register A. The registers and networks sit outside the block. The sequencer only drives the mode pins of the registers, their serial scan inputs and an input-isolate pin per register. It also reads their serial scan outputs.

After a start pulse the sequencer runs five phases in a fixed order:

1. Seed A through its scan path while B clears.
2. A generates pseudorandom vectors and B compresses the responses of network 1.
3. B's signature is unloaded and compared against a programmed value. In the same phase B is reseeded and A is cleared.
4. The roles reverse: B generates and A compresses the responses of network 2.
5. A's signature is unloaded and compared against the second programmed value.

The outcome is shown as done, pass and one fail flag per network.

All pins are plain control and status. The scan path has no back-pressure: each attached register must take one shift in every cycle of a scan phase. The seed, cycle count and both expected signatures must stay stable from start until done.

Top module: `bist_pair_seq`

## Requirements
- R1: A synchronous high `rst` returns the block to idle. In idle both mode outputs are 11 (normal), and done, pass, both fail flags and both isolate outputs are low.
- R2: Mode codes are 11 normal, 00 shift, 10 signature and 01 clear. A shift moves toward the MSB and takes the new bit at bit 0, so scan-out is the MSB. On start, A is in shift mode for exactly W cycles while `scan_in_a` carries `seed` MSB first, and B is in clear mode.
- R3: The first generation phase then lasts `gen_cycles` cycles, with a value of 0 treated as 1. Both modes are 10, `iso_a` is high and `iso_b` is low.
- R4: The next W cycles put B in shift mode and A in clear mode. The block captures `scan_out_b` MSB first while driving `seed` MSB first on `scan_in_b`. `fail_n1` is set exactly when the captured word differs from `golden_n1`.
- R5: The second generation phase lasts the same number of cycles as the first. Both modes are 10, `iso_b` is high and `iso_a` is low.
- R6: The last W cycles put A in shift mode and B in normal mode. The block captures `scan_out_a` MSB first. `fail_n2` is set exactly when the captured word differs from `golden_n2`.
- R7: A run is busy for 3*W + 2*max(`gen_cycles`,1) cycles and then raises done. Done, the fail flags and normal mode on both registers then hold until the next start.
- R8: `pass` is high only while done is high and neither fail flag is set.
- R9: A start pulse while a run is busy has no effect on its duration or its result.
- R10: A start while done begins a new run: done drops on the next cycle, and the flags are re-evaluated by that run.
- R11: With the ring attached, a fault in network 1 can set only `fail_n1`, and a fault in network 2 can set only `fail_n2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (honoured in idle or done) |
| gen_cycles | input | CW | Length of each generation phase |
| seed | input | W | Scan pattern loaded into each generator |
| golden_n1 | input | W | Expected signature of network 1 |
| golden_n2 | input | W | Expected signature of network 2 |
| scan_out_a | input | 1 | Serial output of register A |
| scan_out_b | input | 1 | Serial output of register B |
| mode_a | output | 2 | Mode of register A |
| mode_b | output | 2 | Mode of register B |
| iso_a | output | 1 | Register A ignores its parallel inputs (pure generator) |
| iso_b | output | 1 | Register B ignores its parallel inputs (pure generator) |
| scan_in_a | output | 1 | Serial input of register A |
| scan_in_b | output | 1 | Serial input of register B |
| done | output | 1 | Run complete |
| pass | output | 1 | Both signatures matched |
| fail_n1 | output | 1 | Network 1 signature mismatch |
| fail_n2 | output | 1 | Network 2 signature mismatch |

## Verification
Every nonzero 4-bit seed is swept against generation lengths of 0, 1, 5 and 17. Each combination runs with no fault, a stuck-at in network 1, a stuck-at in network 2 and both, and the bench predicts each signature with its own arithmetic model of the ring. The fault-free runs show that seeding, phase lengths and scan ordering line up. The single-fault runs show that a corrupted network reaches only its own flag, and any aliasing is predicted rather than assumed. Separate runs use a deliberately wrong second golden value, a start pulse mid-run and a reset mid-run, which separate the comparison, ignored-start and return-to-idle behaviour from the normal flow.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_LOAD_A, PH_GEN_A, PH_SWAP, PH_GEN_B, PH_DRAIN, PH_DONE
  } phase_t;

  typedef logic [1:0] mode_t;
  localparam mode_t MD_NORMAL = 2'b11;
  localparam mode_t MD_SHIFT  = 2'b00;
  localparam mode_t MD_SIG    = 2'b10;
  localparam mode_t MD_CLEAR  = 2'b01;
endpackage

// File: rtl/bist_phase_ctl.sv
module bist_phase_ctl
  import bist_seq_pkg::*;
#(
  parameter int W  = 4,
  parameter int CW = 8,
  parameter int KW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] gen_cycles,
  output phase_t        phase,
  output logic [KW-1:0] cnt,
  output logic          last
);
  phase_t        nxt;
  logic          advance;
  logic [KW-1:0] gen_load;
  logic [KW-1:0] nxt_load;

  // zero-length generation is stretched to one cycle
  assign gen_load = (gen_cycles == '0) ? '0 : KW'(gen_cycles) - KW'(1);
  assign last     = (cnt == '0);

  always_comb begin
    case (phase)
      PH_LOAD_A: nxt = PH_GEN_A;
      PH_GEN_A:  nxt = PH_SWAP;
      PH_SWAP:   nxt = PH_GEN_B;
      PH_GEN_B:  nxt = PH_DRAIN;
      PH_DRAIN:  nxt = PH_DONE;
      default:   nxt = PH_LOAD_A;
    endcase
    if (nxt == PH_GEN_A || nxt == PH_GEN_B) nxt_load = gen_load;
    else if (nxt == PH_DONE)                nxt_load = '0;
    else                                    nxt_load = KW'(W - 1);
    advance = (phase == PH_IDLE || phase == PH_DONE) ? start : last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (advance) begin
      phase <= nxt;
      cnt   <= nxt_load;
    end else if (!last) begin
      cnt   <= cnt - KW'(1);
    end
  end
endmodule

// File: rtl/bist_mode_dec.sv
module bist_mode_dec
  import bist_seq_pkg::*;
(
  input  phase_t     phase,
  output logic [1:0] mode_a,
  output logic [1:0] mode_b,
  output logic       iso_a,
  output logic       iso_b
);
  always_comb begin
    mode_a = MD_NORMAL;
    mode_b = MD_NORMAL;
    iso_a  = 1'b0;
    iso_b  = 1'b0;
    case (phase)
      PH_LOAD_A: begin mode_a = MD_SHIFT; mode_b = MD_CLEAR; end
      PH_GEN_A:  begin mode_a = MD_SIG;   mode_b = MD_SIG; iso_a = 1'b1; end
      PH_SWAP:   begin mode_a = MD_CLEAR; mode_b = MD_SHIFT; end
      PH_GEN_B:  begin mode_a = MD_SIG;   mode_b = MD_SIG; iso_b = 1'b1; end
      PH_DRAIN:  begin mode_a = MD_SHIFT; mode_b = MD_NORMAL; end
      default: ;
    endcase
  end
endmodule

// File: rtl/bist_scan_path.sv
module bist_scan_path
  import bist_seq_pkg::*;
#(
  parameter int W  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_t        phase,
  input  logic [IW-1:0] idx,
  input  logic          last,
  input  logic [W-1:0]  seed,
  input  logic [W-1:0]  golden_n1,
  input  logic [W-1:0]  golden_n2,
  input  logic          scan_out_a,
  input  logic          scan_out_b,
  output logic          scan_in_a,
  output logic          scan_in_b,
  output logic          fail_n1,
  output logic          fail_n2
);
  logic [W-1:0] sig;
  logic [W-1:0] full;
  logic         cap_bit;
  logic         seed_bit;

  // index counts down from W-1, so the seed leaves MSB first
  assign seed_bit  = seed[idx];
  assign scan_in_a = (phase == PH_LOAD_A) & seed_bit;
  assign scan_in_b = (phase == PH_SWAP) & seed_bit;
  assign cap_bit   = (phase == PH_SWAP) ? scan_out_b : scan_out_a;
  assign full      = {sig[W-2:0], cap_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      sig     <= '0;
      fail_n1 <= 1'b0;
      fail_n2 <= 1'b0;
    end else begin
      if (phase == PH_SWAP || phase == PH_DRAIN) sig <= full;
      if (phase == PH_LOAD_A) begin
        fail_n1 <= 1'b0;
        fail_n2 <= 1'b0;
      end
      if (phase == PH_SWAP && last)  fail_n1 <= (full != golden_n1);
      if (phase == PH_DRAIN && last) fail_n2 <= (full != golden_n2);
    end
  end
endmodule

// File: rtl/bist_pair_seq.sv
module bist_pair_seq
  import bist_seq_pkg::*;
#(
  parameter int W  = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] gen_cycles,
  input  logic [W-1:0]  seed,
  input  logic [W-1:0]  golden_n1,
  input  logic [W-1:0]  golden_n2,
  input  logic          scan_out_a,
  input  logic          scan_out_b,
  output logic [1:0]    mode_a,
  output logic [1:0]    mode_b,
  output logic          iso_a,
  output logic          iso_b,
  output logic          scan_in_a,
  output logic          scan_in_b,
  output logic          done,
  output logic          pass,
  output logic          fail_n1,
  output logic          fail_n2
);
  localparam int IW = (W > 2) ? $clog2(W) : 1;
  localparam int KW = (CW > IW) ? CW : IW;

  phase_t        phase;
  logic [KW-1:0] cnt;
  logic          last;

  bist_phase_ctl #(.W(W), .CW(CW), .KW(KW)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .gen_cycles(gen_cycles),
    .phase(phase), .cnt(cnt), .last(last)
  );

  bist_mode_dec u_dec (
    .phase(phase), .mode_a(mode_a), .mode_b(mode_b),
    .iso_a(iso_a), .iso_b(iso_b)
  );

  bist_scan_path #(.W(W), .IW(IW)) u_scan (
    .clk(clk), .rst(rst), .phase(phase), .idx(cnt[IW-1:0]), .last(last),
    .seed(seed), .golden_n1(golden_n1), .golden_n2(golden_n2),
    .scan_out_a(scan_out_a), .scan_out_b(scan_out_b),
    .scan_in_a(scan_in_a), .scan_in_b(scan_in_b),
    .fail_n1(fail_n1), .fail_n2(fail_n2)
  );

  assign done = (phase == PH_DONE);
  assign pass = done & ~fail_n1 & ~fail_n2;
endmodule

// File: rtl/bist_pair_seq_chk.sv
module bist_pair_seq_chk #(
  parameter int W = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [1:0] mode_a,
  input logic [1:0] mode_b,
  input logic       iso_a,
  input logic       iso_b,
  input logic       done,
  input logic       pass,
  input logic       fail_n1,
  input logic       fail_n2
);
  localparam int RW = $clog2(W + 2) + 1;
  logic [RW-1:0] shift_run;

  always_ff @(posedge clk) begin
    if (rst) shift_run <= '0;
    else if (mode_a == 2'b00) shift_run <= shift_run + RW'(1);
    else shift_run <= '0;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (mode_a == 2'b11 && mode_b == 2'b11 && !done && !iso_a && !iso_b));

  a_r2_shift_window: assert property (@(posedge clk) disable iff (rst)
    shift_run <= RW'(W));

  a_r3_gen_a_roles: assert property (@(posedge clk) disable iff (rst)
    iso_a |-> (mode_a == 2'b10 && mode_b == 2'b10 && !iso_b));

  a_r4_b_unload_a_clear: assert property (@(posedge clk) disable iff (rst)
    (mode_b == 2'b00) |-> (mode_a == 2'b01));

  a_r5_gen_b_roles: assert property (@(posedge clk) disable iff (rst)
    iso_b |-> (mode_a == 2'b10 && mode_b == 2'b10 && !iso_a));

  a_r7_done_normal: assert property (@(posedge clk) disable iff (rst)
    done |-> (mode_a == 2'b11 && mode_b == 2'b11));

  a_r7_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(fail_n1) && $stable(fail_n2)));

  a_r8_pass_meaning: assert property (@(posedge clk) disable iff (rst)
    pass |-> (done && !fail_n1 && !fail_n2));

  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> !done);
endmodule

bind bist_pair_seq bist_pair_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mode_a(mode_a), .mode_b(mode_b),
  .iso_a(iso_a), .iso_b(iso_b), .done(done), .pass(pass),
  .fail_n1(fail_n1), .fail_n2(fail_n2)
);

// File: tb/sim_bist_pair_seq.sv
module sim_bist_pair_seq;
  localparam int W  = 4;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [CW-1:0] gen_cycles = '0;
  logic [W-1:0]  seed = '0, golden_n1 = '0, golden_n2 = '0;
  logic          scan_out_a, scan_out_b;
  logic [1:0]    mode_a, mode_b;
  logic          iso_a, iso_b, scan_in_a, scan_in_b;
  logic          done, pass, fail_n1, fail_n2;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic flt1 = 1'b0, flt2 = 1'b0;
  logic [3:0] ra, rb;

  always #4 clk = ~clk;

  bist_pair_seq #(.W(W), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .start(start), .gen_cycles(gen_cycles),
    .seed(seed), .golden_n1(golden_n1), .golden_n2(golden_n2),
    .scan_out_a(scan_out_a), .scan_out_b(scan_out_b),
    .mode_a(mode_a), .mode_b(mode_b), .iso_a(iso_a), .iso_b(iso_b),
    .scan_in_a(scan_in_a), .scan_in_b(scan_in_b),
    .done(done), .pass(pass), .fail_n1(fail_n1), .fail_n2(fail_n2)
  );

  // behavioural ring: networks and test registers
  function automatic logic [3:0] net1(input logic [3:0] x, input logic f);
    logic [3:0] y;
    y = {x[3] ^ x[0], x[2] & x[1], x[1] | x[3], ~x[2]};
    if (f) y[2] = 1'b1;
    return y;
  endfunction
  function automatic logic [3:0] net2(input logic [3:0] x, input logic f);
    logic [3:0] y;
    y = {x[0] ^ x[1], x[3], x[2] ^ x[3], x[1] & x[0]};
    if (f) y[0] = 1'b0;
    return y;
  endfunction
  function automatic logic [3:0] lfsr(input logic [3:0] x);
    return {x[2:0], x[3] ^ x[2]};
  endfunction
  function automatic logic [3:0] sig1(input logic [3:0] s, input int n, input logic f);
    logic [3:0] g, c;
    g = s; c = '0;
    for (int i = 0; i < n; i++) begin c = lfsr(c) ^ net1(g, f); g = lfsr(g); end
    return c;
  endfunction
  function automatic logic [3:0] sig2(input logic [3:0] s, input int n, input logic f);
    logic [3:0] g, c;
    g = s; c = '0;
    for (int i = 0; i < n; i++) begin c = lfsr(c) ^ net2(g, f); g = lfsr(g); end
    return c;
  endfunction

  assign scan_out_a = ra[3];
  assign scan_out_b = rb[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      ra <= '0;
      rb <= '0;
    end else begin
      case (mode_a)
        2'b00:   ra <= {ra[2:0], scan_in_a};
        2'b01:   ra <= '0;
        2'b10:   ra <= iso_a ? lfsr(ra) : (lfsr(ra) ^ net2(rb, flt2));
        default: ra <= net2(rb, flt2);
      endcase
      case (mode_b)
        2'b00:   rb <= {rb[2:0], scan_in_b};
        2'b01:   rb <= '0;
        2'b10:   rb <= iso_b ? lfsr(rb) : (lfsr(rb) ^ net1(ra, flt1));
        default: rb <= net1(ra, flt1);
      endcase
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [3:0] s, input int n, input logic f1,
                          input logic f2, input logic bad2, input logic poke);
    int neff, busy, na, nb, sa;
    logic [3:0] g1, g2;
    logic e1, e2;
    neff = (n == 0) ? 1 : n;
    g1 = sig1(s, neff, 1'b0);
    g2 = sig2(s, neff, 1'b0);
    e1 = (sig1(s, neff, f1) != g1);
    e2 = (sig2(s, neff, f2) != g2) || bad2;
    seed = s; gen_cycles = CW'(n); golden_n1 = g1;
    golden_n2 = bad2 ? ~g2 : g2;
    flt1 = f1; flt2 = f2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 done drops after start", int'(done), 0);
    busy = 0; na = 0; nb = 0; sa = 0;
    while (!done && busy < 1000) begin
      start = (poke && (busy == 3 || busy == W + neff + 1)) ? 1'b1 : 1'b0;
      if (iso_a) na++;
      if (iso_b) nb++;
      if (mode_a == 2'b00) sa++;
      busy++;
      @(negedge clk);
    end
    start = 1'b0;
    check(poke ? "R9 busy length with stray start" : "R7 busy length",
          busy, 3 * W + 2 * neff);
    check("R2 cycles A in shift", sa, 2 * W);
    check("R3 first generation length", na, neff);
    check("R5 second generation length", nb, neff);
    check("R4 R11 fail_n1", int'(fail_n1), int'(e1));
    check("R6 R11 fail_n2", int'(fail_n2), int'(e2));
    check("R8 pass", int'(pass), int'(!e1 && !e2));
    repeat (3) @(negedge clk);
    check("R7 done held", int'(done), 1);
    check("R7 flags held", int'({fail_n1, fail_n2}), int'({e1, e2}));
    check("R7 normal modes in done", int'({mode_a, mode_b}), 15);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int nlist[4];
    nlist = '{0, 1, 5, 17};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset modes", int'({mode_a, mode_b}), 15);
    check("R1 reset status", int'({done, pass, fail_n1, fail_n2, iso_a, iso_b}), 0);

    for (int s = 1; s < 16; s++)
      for (int k = 0; k < 4; k++)
        for (int fc = 0; fc < 4; fc++)
          run_case(4'(s), nlist[k], fc[0], fc[1], 1'b0, (fc == 0 && k == 2));

    run_case(4'h9, 6, 1'b0, 1'b0, 1'b1, 1'b0);

    // reset in the middle of a run
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 mid-run reset modes", int'({mode_a, mode_b}), 15);
    check("R1 mid-run reset status", int'({done, pass, iso_a, iso_b}), 0);
    repeat (5) @(negedge clk);
    check("R1 stays idle", int'({done, mode_a, mode_b}), 15);
    run_case(4'h3, 2, 1'b1, 1'b0, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule